// File: doc/BRIEF.md
# Paged External Data RAM

This block is a 2048-byte on-chip data RAM that an 8051-style core reaches through its external data space. The core reaches it in one of two ways. A long access carries a full 16-bit address. Only the low eleven bits of that address select a byte, so the array repeats every 0x0800 bytes across the whole 64 KB space. A short access is an indirect access through an 8-bit pointer. It carries only the low address byte, and a page register supplies the bits above it, so the access lands in one 256-byte page of the array.

The page register sits on the core's special-function register bus at address 0xAA. It is three bits wide and resets to zero. The RAM port uses single-cycle strobes. A write lands on the clock edge where the write strobe is high. Read data appears on the output one cycle after the read strobe and stays there until the next read.

Top module: `xram_paged`

## Requirements
- R1: After reset the page register reads 0x00 at SFR address 0xAA and `mem_rdata` is 0x00.
- R2: A long access (`mem_short` = 0) selects array byte `mem_addr[10:0]`. Bits 15..11 are ignored, so address A and A + k*0x0800 reach the same byte.
- R3: A short access (`mem_short` = 1) selects array byte {page[2:0], `mem_addr[7:0]`}. With the page at 0x01, short accesses reach long addresses 0x0100..0x01FF.
- R4: The page register is written only when `sfr_we` is high and `sfr_addr` is 0xAA. Only write-data bits 2..0 are stored. Bits 7..3 always read as zero.
- R5: `sfr_rdata` is 0x00 whenever `sfr_addr` is not 0xAA.
- R6: When a page write and a short access happen in the same cycle, the access uses the old page. The new page takes effect from the next cycle.
- R7: A read strobe in cycle n puts the addressed byte on `mem_rdata` after that edge. `mem_rdata` holds its value in every cycle without a read strobe, including cycles that only write.
- R8: A write stores `mem_wdata` on the clock edge where `mem_wr` is high. A read and a write to the same byte in the same cycle return the byte's previous contents.
- R9: A short access ignores `mem_addr[15:8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd | input | 1 | RAM read strobe |
| mem_wr | input | 1 | RAM write strobe |
| mem_short | input | 1 | 1 = 8-bit indirect access, 0 = 16-bit access |
| mem_addr | input | 16 | RAM access address (only the low byte is used for short accesses) |
| mem_wdata | input | 8 | RAM write data |
| mem_rdata | output | 8 | Registered RAM read data |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wdata | input | 8 | SFR bus write data |
| sfr_we | input | 1 | SFR bus write enable |
| sfr_rdata | output | 8 | SFR bus read data (page register or zero) |

## Verification
The hardest case to reach is a page-register write and a short RAM write landing in the same clock cycle. Only then does the old-page-versus-new-page choice matter. The bench drives both strobes together on one edge. It first seeds the byte under the new page with a known value. It then reads both candidate locations back through long addresses, which shows which page was used. Aliasing is checked as follows. Long addresses from 0x0000 to 0x0FFF are filled linearly, which wraps twice over the array. A second pass then reads from a far alias range and compares against a model indexed by the low eleven address bits.

// File: rtl/xram_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the paged external data RAM.
// Assumes: the page register and RAM array widths come from module parameters.
package xram_pkg;

    // Kind of RAM access presented by the core.
    typedef enum logic {
        ACC_LONG  = 1'b0,   // full 16-bit address
        ACC_SHORT = 1'b1    // low byte only, page register supplies the rest
    } acc_kind_e;

    // Width of the low address byte carried by a short access.
    localparam int unsigned LOW_BYTE_W = 8;

endpackage : xram_pkg

// File: rtl/xram_page_reg.sv
`timescale 1ns/1ps
// Module: xram_page_reg
// Holds the RAM page-select value on the SFR bus. It is written at address
// SFR_ADDR when the write enable is high. Only the low PAGE_W bits are stored,
// and the upper bits always read as zero. Reads of any other SFR address return
// zero. Assumes a synchronous active-low reset.
module xram_page_reg #(
    parameter int unsigned   DATA_W   = 8,
    parameter int unsigned   PAGE_W   = 3,
    parameter logic [7:0]    SFR_ADDR = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_we,
    output logic [PAGE_W-1:0] page_o,
    output logic [DATA_W-1:0] sfr_rdata
);

    localparam int unsigned PAD_W = DATA_W - PAGE_W;

    logic              hit;
    logic [PAGE_W-1:0] page_q;
    logic              unused_wdata_hi;

    // Decode whether the SFR bus addresses this register.
    always_comb begin
        hit = (sfr_addr == SFR_ADDR);
    end

    // Capture the page-select field on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (sfr_we && hit) begin
            page_q <= sfr_wdata[PAGE_W-1:0];
        end
    end

    // Drive SFR read data: the zero-padded page when addressed, zero otherwise.
    always_comb begin
        if (hit) begin
            sfr_rdata = {{PAD_W{1'b0}}, page_q};
        end else begin
            sfr_rdata = '0;
        end
    end

    assign page_o          = page_q;
    assign unused_wdata_hi = ^sfr_wdata[DATA_W-1:PAGE_W];

endmodule : xram_page_reg

// File: rtl/xram_addr_map.sv
`timescale 1ns/1ps
// Module: xram_addr_map
// Turns a core address into an array index. A long access keeps the low IDX_W
// bits, which aliases the array across the whole address space. A short access
// joins the page value with the low address byte. Assumes
// IDX_W == PAGE_W + LOW_BYTE_W.
module xram_addr_map
    import xram_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned PAGE_W = 3
) (
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] long_idx;
    logic [IDX_W-1:0] short_idx;
    logic             unused_addr_hi;

    generate
        if (ADDR_W > IDX_W) begin : g_alias
            // Upper address bits do not take part in selection.
            assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W];
        end else begin : g_no_alias
            assign unused_addr_hi = 1'b0;
        end
    endgenerate

    // Form both candidate indices.
    always_comb begin
        long_idx  = addr[IDX_W-1:0];
        short_idx = {page, addr[LOW_BYTE_W-1:0]};
    end

    // Select the index for the current access kind.
    always_comb begin
        case (kind)
            ACC_SHORT: idx = short_idx;
            default:   idx = long_idx;
        endcase
    end

endmodule : xram_addr_map

// File: rtl/xram_array.sv
`timescale 1ns/1ps
// Module: xram_array
// Single-port synchronous byte array. A write lands on the edge where wr is
// high. A read registers the addressed byte on the edge where rd is high, and
// the output holds between reads. A read and a write to the same index in the
// same cycle return the old byte. Contents are not reset. The read register is.
module xram_array #(
    parameter int unsigned DEPTH  = 2048,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Store write data into the array.
    always_ff @(posedge clk) begin
        if (wr) begin
            mem[idx] <= wdata;
        end
    end

    // Register read data, reading the pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= mem[idx];
        end
    end

    assign rdata = rdata_q;

endmodule : xram_array

// File: rtl/xram_paged.sv
`timescale 1ns/1ps
// Module: xram_paged (top)
// A paged external data RAM for an 8051-style core. A RAM port takes strobes
// plus an access-kind flag, and an SFR port holds the page register. Assumes
// the core asserts at most one of each strobe per cycle and never writes the
// RAM during reset.
module xram_paged
    import xram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned DEPTH    = 2048,
    parameter logic [7:0]  SFR_ADDR = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              mem_short,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    input  logic [7:0]        sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_we,
    output logic [DATA_W-1:0] sfr_rdata
);

    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned PAGE_W = IDX_W - LOW_BYTE_W;

    acc_kind_e         kind;
    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;

    // Translate the access flag into the access-kind type.
    always_comb begin
        kind = mem_short ? ACC_SHORT : ACC_LONG;
    end

    xram_page_reg #(
        .DATA_W   (DATA_W),
        .PAGE_W   (PAGE_W),
        .SFR_ADDR (SFR_ADDR)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_we    (sfr_we),
        .page_o    (page),
        .sfr_rdata (sfr_rdata)
    );

    xram_addr_map #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .PAGE_W (PAGE_W)
    ) u_map (
        .kind (kind),
        .addr (mem_addr),
        .page (page),
        .idx  (idx)
    );

    xram_array #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (mem_rd),
        .wr    (mem_wr),
        .idx   (idx),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule : xram_paged

// File: rtl/xram_paged_chk.sv
`timescale 1ns/1ps
// Module: xram_paged_chk
// Property checker bound to xram_paged. It watches the ports together with the
// page value and array index that separate submodules produce.
module xram_paged_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IDX_W    = 11,
    parameter int unsigned PAGE_W   = 3,
    parameter logic [7:0]  SFR_ADDR = 8'hAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_short,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [7:0]        sfr_addr,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic              sfr_we,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic [PAGE_W-1:0] cur_page,
    input logic [IDX_W-1:0]  cur_idx
);

    AST_PAGE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == SFR_ADDR) |-> (sfr_rdata[DATA_W-1:PAGE_W] == '0)); // R4

    AST_PAGE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_page != $past(cur_page)) |-> $past(sfr_we && (sfr_addr == SFR_ADDR))); // R4

    AST_SFR_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != SFR_ADDR) |-> (sfr_rdata == '0)); // R5

    AST_LONG_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_short && (mem_rd || mem_wr)) |-> (cur_idx == mem_addr[IDX_W-1:0])); // R2

    AST_SHORT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_short && (mem_rd || mem_wr)) |-> (cur_idx[IDX_W-1:IDX_W-PAGE_W] == cur_page)); // R3

    AST_PAGE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && (sfr_addr == SFR_ADDR)) |=> (cur_page == $past(sfr_wdata[PAGE_W-1:0]))); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> $stable(mem_rdata)); // R7

endmodule : xram_paged_chk

bind xram_paged xram_paged_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .PAGE_W   (PAGE_W),
    .SFR_ADDR (SFR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_short (mem_short),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .sfr_we    (sfr_we),
    .sfr_rdata (sfr_rdata),
    .cur_page  (page),
    .cur_idx   (idx)
);

// File: tb/xram_paged_test.sv
`timescale 1ns/1ps
// Bench for xram_paged: linear fill with wrap, a vector table, then directed
// corner cases. Expected values come from a bench-side model of the requirements.
module xram_paged_test;

    localparam logic [7:0] PG_ADDR = 8'hAA;

    // Vector layout: [35:32] op, [31:16] address, [15:8] data, [7:0] expected.
    localparam logic [3:0] OP_WR16 = 4'd0;
    localparam logic [3:0] OP_RD16 = 4'd1;
    localparam logic [3:0] OP_SETP = 4'd2;
    localparam logic [3:0] OP_WR8  = 4'd3;
    localparam logic [3:0] OP_RD8  = 4'd4;
    localparam int NVEC = 14;
    localparam logic [35:0] VEC [NVEC] = '{
        {OP_SETP, 16'h0000, 8'h03, 8'h03},
        {OP_WR8,  16'hFF42, 8'h5A, 8'h00},   // R9: high byte ignored
        {OP_RD16, 16'h0342, 8'h00, 8'h5A},   // R3
        {OP_RD16, 16'hF342, 8'h00, 8'h5A},   // R2 alias
        {OP_WR16, 16'h2100, 8'hC3, 8'h00},
        {OP_SETP, 16'h0000, 8'h01, 8'h01},
        {OP_RD8,  16'h0000, 8'h00, 8'hC3},   // R3 page 1 -> 0x0100
        {OP_SETP, 16'h0000, 8'hFF, 8'h07},   // R4 upper bits dropped
        {OP_WR8,  16'h0011, 8'h99, 8'h00},
        {OP_RD16, 16'h0711, 8'h00, 8'h99},
        {OP_RD16, 16'h7F11, 8'h00, 8'h99},   // R2 alias
        {OP_SETP, 16'h0000, 8'h0A, 8'h02},   // R4
        {OP_WR16, 16'h0255, 8'h21, 8'h00},
        {OP_RD8,  16'hAB55, 8'h00, 8'h21}    // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        mem_short = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic [7:0]  mem_rdata;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_rdata;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    logic [7:0] ref_mem [2048];
    logic [2:0] page_m = '0;

    always #10 clk = ~clk;

    xram_paged uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_short (mem_short),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_we    (sfr_we),
        .sfr_rdata (sfr_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] model_idx(input logic shrt, input logic [15:0] a);
        return shrt ? {page_m, a[7:0]} : a[10:0];
    endfunction

    task automatic mem_write(input logic shrt, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_short = shrt; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
        ref_mem[model_idx(shrt, a)] = d;
    endtask

    task automatic mem_read(input logic shrt, input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        mem_rd = 1'b1; mem_short = shrt; mem_addr = a;
        @(negedge clk);
        mem_rd = 1'b0;
        d = mem_rdata;
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
        if (a == PG_ADDR) page_m = d[2:0];
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd_v;
        logic [7:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sfr_read(PG_ADDR, rd_v);
        check("R1 page after reset", rd_v, 8'h00);
        check("R1 rdata after reset", mem_rdata, 8'h00);

        // R2: linear fill across two array wraps, then read back from an alias range
        for (int a = 0; a < 4096; a++) begin
            logic [15:0] aa;
            aa = 16'(a);
            mem_write(1'b0, aa, aa[7:0] ^ {aa[11:8], aa[11:8]} ^ 8'h3C);
        end
        for (int i = 0; i < 2048; i++) begin
            logic [15:0] aa;
            aa = 16'h3800 + 16'(i);
            mem_read(1'b0, aa, rd_v);
            check("R2 alias readback", rd_v, ref_mem[i]);
        end

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  op;
            logic [15:0] va;
            logic [7:0]  vd;
            logic [7:0]  ve;
            {op, va, vd, ve} = VEC[v];
            case (op)
                OP_WR16: mem_write(1'b0, va, vd);
                OP_WR8:  mem_write(1'b1, va, vd);
                OP_RD16: begin mem_read(1'b0, va, rd_v); check("R2 R3 R9 table read16", rd_v, ve); end
                OP_RD8:  begin mem_read(1'b1, va, rd_v); check("R3 R9 table read8", rd_v, ve); end
                default: begin
                    sfr_write(PG_ADDR, vd);
                    sfr_read(PG_ADDR, rd_v);
                    check("R4 table page readback", rd_v, ve);
                end
            endcase
        end

        // R4/R5: write to another SFR address is ignored; its read is zero
        sfr_write(PG_ADDR, 8'h05);
        sfr_write(8'hAB, 8'h02);
        sfr_read(PG_ADDR, rd_v);
        check("R4 other-address write ignored", rd_v, 8'h05);
        sfr_read(8'hAB, rd_v);
        check("R5 other SFR address reads zero", rd_v, 8'h00);
        sfr_read(8'h00, rd_v);
        check("R5 SFR address 0x00 reads zero", rd_v, 8'h00);
        // R4: write enable low leaves page unchanged
        @(negedge clk);
        sfr_addr = PG_ADDR; sfr_wdata = 8'h06; sfr_we = 1'b0;
        @(negedge clk);
        sfr_read(PG_ADDR, rd_v);
        check("R4 no write without enable", rd_v, 8'h05);

        // R6: same-cycle page write and short write use the old page
        sfr_write(PG_ADDR, 8'h01);
        mem_write(1'b0, 16'h0510, 8'h00);
        mem_write(1'b0, 16'h0110, 8'h11);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = PG_ADDR; sfr_wdata = 8'h05;
        mem_wr = 1'b1; mem_short = 1'b1; mem_addr = 16'h0010; mem_wdata = 8'h77;
        @(negedge clk);
        sfr_we = 1'b0; mem_wr = 1'b0;
        page_m = 3'd5;
        mem_read(1'b0, 16'h0110, rd_v);
        check("R6 write used old page", rd_v, 8'h77);
        mem_read(1'b0, 16'h0510, rd_v);
        check("R6 new page untouched", rd_v, 8'h00);
        mem_read(1'b1, 16'h0010, rd_v);
        check("R6 new page applies next cycle", rd_v, 8'h00);

        // R8: read and write the same byte in one cycle returns old contents
        mem_write(1'b0, 16'h0123, 8'h11);
        @(negedge clk);
        mem_rd = 1'b1; mem_wr = 1'b1; mem_short = 1'b0; mem_addr = 16'h0123; mem_wdata = 8'h22;
        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0;
        check("R8 read-during-write old data", mem_rdata, 8'h11);
        mem_read(1'b0, 16'h0123, rd_v);
        check("R8 write stored", rd_v, 8'h22);

        // R7: output holds through idle and write-only cycles
        held = mem_rdata;
        repeat (3) @(negedge clk);
        check("R7 hold when idle", mem_rdata, held);
        mem_write(1'b0, 16'h0124, 8'hE7);
        check("R7 hold across write", mem_rdata, held);
        mem_read(1'b0, 16'h0124, rd_v);
        check("R7 one-cycle read latency", rd_v, 8'hE7);

        // R1: reset in mid-run clears page and read data
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        page_m = 3'd0;
        sfr_read(PG_ADDR, rd_v);
        check("R1 page after second reset", rd_v, 8'h00);
        check("R1 rdata after second reset", mem_rdata, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule : xram_paged_test